// File: doc/BRIEF.md
# Counter-Matrix Group Error Corrector

This block sits on the read path of a memory protected as a group of words. One group is a matrix of 128 data bits in 4 rows of 32 bits. Each row is split into 8 symbols of 4 bits. Next to the data, the memory keeps 16 horizontal check bits and 32 vertical check bits. A horizontal check bit is the parity of one bit lane across all symbols of one row. A vertical check bit is the parity of one column across all rows.

On each clock the block re-encodes the data it reads with the same rules the writer used. It compares the result with the stored check bits, so no separate syndrome-decoding stage is needed. The two mismatch vectors are the horizontal and vertical syndromes. From them the block raises an error flag and forms an upset prediction from the ones counts of the two syndromes. It then flips the data bits that the syndromes point to. All outputs are registered, one cycle after the inputs.

Top module: `cmc_group_corrector`

## Requirements
- R1: Reset is synchronous and active low. While it is applied, `data_o`, `err_o` and `pred_o` are zero on the next rising edge, whatever the inputs are.
- R2: Data bit (r, c) is `data_i[r*32 + c]`. Horizontal check bit `hpar_i[r*4 + j]` is the XOR of the bits (r, c) with c mod 4 = j. Vertical check bit `vpar_i[c]` is the XOR of column c over all rows. Each syndrome bit is the stored check bit XOR the recomputed check bit.
- R3: `err_o` is 1 exactly when at least one horizontal or vertical syndrome bit is set. It appears one cycle after the inputs.
- R4: When both syndromes are zero, `data_o` equals `data_i` of the previous cycle and `pred_o` is zero.
- R5: `pred_o[10:6]` is the number of set horizontal syndrome bits (0 to 16). `pred_o[5:0]` is the number of set vertical syndrome bits (0 to 32).
- R6: When both syndromes are nonzero, bit (r, c) is flipped exactly when vertical syndrome bit c and horizontal syndrome bit r*4 + (c mod 4) are both set.
- R7: When only the vertical syndrome is nonzero, the flagged columns are flipped in row 0 only.
- R8: When only the horizontal syndrome is nonzero, each set bit r*4 + j flips bit (r, 28 + j), which is lane j of the top symbol of row r.
- R9: Any single-bit upset, and any two horizontally adjacent upsets in one row, come out restored to the original data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 128 | Group data as read, row r at bits r*32+31 down to r*32 |
| hpar_i | input | 16 | Stored horizontal lane parity, bit r*4+j |
| vpar_i | input | 32 | Stored vertical column parity, bit c |
| data_o | output | 128 | Corrected group data |
| err_o | output | 1 | A syndrome mismatch was seen |
| pred_o | output | 11 | Upset prediction: {horizontal syndrome weight, vertical syndrome weight} |

## Verification
The bench sweeps every single-bit flip and every horizontally adjacent pair in every row. A locator that mixed up the lane index of a column, or used the wrong row stride, would leave a bit flipped or flip a neighbour. It sweeps every vertically adjacent pair, where the vertical syndrome cancels and only the horizontal rule applies. A design that still applied the joint rule there would change nothing. It also drives a whole inverted row (vertical syndrome only) and an inverted top symbol in every row (horizontal syndrome only), where a swapped fallback rule would corrupt clean rows. Random multi-bit patterns check the prediction counts and the error flag against an arithmetic model.

// File: rtl/cmc_pkg.sv
// Package: shared defaults and a width helper for the group corrector.
// Assumes: counts are unsigned and never exceed the vector they count.
package cmc_pkg;
    localparam int DEF_ROWS = 4;
    localparam int DEF_SYMS = 8;
    localparam int DEF_SYMW = 4;

    // Bits needed to hold a count of 0..n.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/cmc_syndrome.sv
// Module: re-encodes the read group and compares it with the stored check bits.
// Assumes: row r at data[r*COLS +: COLS]; lane j of a row is every column with c mod SYMW = j.
module cmc_syndrome #(
    parameter int ROWS = cmc_pkg::DEF_ROWS,
    parameter int SYMS = cmc_pkg::DEF_SYMS,
    parameter int SYMW = cmc_pkg::DEF_SYMW,
    localparam int COLS = SYMS * SYMW,
    localparam int TOT  = ROWS * COLS,
    localparam int HPW  = ROWS * SYMW
) (
    input  logic [TOT-1:0]  data,
    input  logic [HPW-1:0]  hpar,
    input  logic [COLS-1:0] vpar,
    output logic [HPW-1:0]  hsyn,
    output logic [COLS-1:0] vsyn
);
    logic [HPW-1:0]  h_re;
    logic [COLS-1:0] v_re;

    // Recompute lane parity per row and column parity over all rows.
    always_comb begin
        h_re = '0;
        v_re = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                h_re[r*SYMW + (c % SYMW)] = h_re[r*SYMW + (c % SYMW)] ^ data[r*COLS + c];
                v_re[c] = v_re[c] ^ data[r*COLS + c];
            end
        end
    end

    // Mismatch between stored and recomputed check bits.
    assign hsyn = hpar ^ h_re;
    assign vsyn = vpar ^ v_re;
endmodule

// File: rtl/cmc_predictor.sv
// Module: counts set syndrome bits to predict the upset size.
// Assumes: output is {horizontal count, vertical count}.
module cmc_predictor #(
    parameter int HPW = 16,
    parameter int COLS = 32,
    localparam int HCW = cmc_pkg::cnt_width(HPW),
    localparam int VCW = cmc_pkg::cnt_width(COLS)
) (
    input  logic [HPW-1:0]     hsyn,
    input  logic [COLS-1:0]    vsyn,
    output logic [HCW+VCW-1:0] pred
);
    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;

    // Ones count of each syndrome.
    always_comb begin
        hcnt = '0;
        vcnt = '0;
        for (int i = 0; i < HPW; i++)  hcnt = hcnt + HCW'(hsyn[i]);
        for (int i = 0; i < COLS; i++) vcnt = vcnt + VCW'(vsyn[i]);
    end

    assign pred = {hcnt, vcnt};
endmodule

// File: rtl/cmc_locator.sv
// Module: turns the two syndromes into a flip mask over the group.
// Assumes: both set -> cross of column and row lane; vertical only -> row 0;
// horizontal only -> lane bit of the top symbol in each flagged row.
module cmc_locator #(
    parameter int ROWS = cmc_pkg::DEF_ROWS,
    parameter int SYMS = cmc_pkg::DEF_SYMS,
    parameter int SYMW = cmc_pkg::DEF_SYMW,
    localparam int COLS = SYMS * SYMW,
    localparam int TOT  = ROWS * COLS,
    localparam int HPW  = ROWS * SYMW
) (
    input  logic [HPW-1:0]  hsyn,
    input  logic [COLS-1:0] vsyn,
    output logic [TOT-1:0]  mask
);
    logic h_any, v_any;
    assign h_any = |hsyn;
    assign v_any = |vsyn;

    // Select the location rule from which syndromes are active.
    always_comb begin
        mask = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (h_any && v_any)
                    mask[r*COLS + c] = vsyn[c] & hsyn[r*SYMW + (c % SYMW)];
                else if (v_any)
                    mask[r*COLS + c] = (r == 0) & vsyn[c];
                else if (h_any)
                    mask[r*COLS + c] = (c >= COLS - SYMW) & hsyn[r*SYMW + (c % SYMW)];
            end
        end
    end
endmodule

// File: rtl/cmc_group_corrector.sv
// Module: top of the read-path corrector; syndrome, predictor, locator, and a
// registered XOR corrector. Assumes check bits were written with the same rules.
module cmc_group_corrector #(
    parameter int ROWS = cmc_pkg::DEF_ROWS,
    parameter int SYMS = cmc_pkg::DEF_SYMS,
    parameter int SYMW = cmc_pkg::DEF_SYMW,
    localparam int COLS = SYMS * SYMW,
    localparam int TOT  = ROWS * COLS,
    localparam int HPW  = ROWS * SYMW,
    localparam int PW   = cmc_pkg::cnt_width(HPW) + cmc_pkg::cnt_width(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TOT-1:0]  data_i,
    input  logic [HPW-1:0]  hpar_i,
    input  logic [COLS-1:0] vpar_i,
    output logic [TOT-1:0]  data_o,
    output logic            err_o,
    output logic [PW-1:0]   pred_o
);
    logic [HPW-1:0]  hsyn;
    logic [COLS-1:0] vsyn;
    logic [TOT-1:0]  mask;
    logic [PW-1:0]   pred;

    cmc_syndrome #(.ROWS(ROWS), .SYMS(SYMS), .SYMW(SYMW)) syn_i (
        .data(data_i), .hpar(hpar_i), .vpar(vpar_i), .hsyn(hsyn), .vsyn(vsyn)
    );

    cmc_predictor #(.HPW(HPW), .COLS(COLS)) pred_i (
        .hsyn(hsyn), .vsyn(vsyn), .pred(pred)
    );

    cmc_locator #(.ROWS(ROWS), .SYMS(SYMS), .SYMW(SYMW)) loc_i (
        .hsyn(hsyn), .vsyn(vsyn), .mask(mask)
    );

    // Output stage: apply the flip mask and register flag and prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            err_o  <= 1'b0;
            pred_o <= '0;
        end else begin
            data_o <= data_i ^ mask;
            err_o  <= (|hsyn) | (|vsyn);
            pred_o <= pred;
        end
    end

    // R3: any mismatch raises the flag on the next cycle.
    p_flag_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hsyn) || (|vsyn)) |=> err_o);

    // R4: a clean group passes through unchanged with zero prediction.
    p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((hsyn == '0) && (vsyn == '0)) |=> (!err_o && pred_o == '0 && data_o == $past(data_i)));

    // R5: no flag means no predicted upsets.
    p_pred_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (pred_o == '0));

    // R7: vertical-only syndrome never touches rows above row 0.
    p_vonly_row0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((hsyn == '0) && (|vsyn)) |-> (mask[TOT-1:COLS] == '0));

    // R8: horizontal-only syndrome touches only the top symbol of each row.
    for (genvar r = 0; r < ROWS; r++) begin : g_honly_chk
        p_honly_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((vsyn == '0) && (|hsyn)) |-> (mask[r*COLS +: COLS-SYMW] == '0));
    end
endmodule

// File: tb/cmc_group_corrector_tb_top.sv
module cmc_group_corrector_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] data_i = '0;
    logic [15:0]  hpar_i = '0;
    logic [31:0]  vpar_i = '0;
    logic [127:0] data_o;
    logic         err_o;
    logic [10:0]  pred_o;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cmc_group_corrector dut_i (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .hpar_i(hpar_i), .vpar_i(vpar_i),
        .data_o(data_o), .err_o(err_o), .pred_o(pred_o)
    );

    function automatic logic [15:0] f_h(input logic [127:0] d);
        logic [15:0] h = '0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 32; c++) h[r*4 + c%4] ^= d[r*32 + c];
        return h;
    endfunction

    function automatic logic [31:0] f_v(input logic [127:0] d);
        logic [31:0] v = '0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 32; c++) v[c] ^= d[r*32 + c];
        return v;
    endfunction

    // Expected flip mask from R6, R7, R8.
    function automatic logic [127:0] f_mask(input logic [15:0] hs, input logic [31:0] vs);
        logic [127:0] m = '0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 32; c++) begin
                if (hs != 0 && vs != 0) m[r*32 + c] = vs[c] & hs[r*4 + c%4];
                else if (vs != 0)       m[r*32 + c] = (r == 0) & vs[c];
                else if (hs != 0)       m[r*32 + c] = (c >= 28) & hs[r*4 + c%4];
            end
        return m;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present orig^flip with orig's check bits; check one cycle later.
    task automatic run_case(input logic [127:0] orig, input logic [127:0] flip,
                            input bit restore, input string tag);
        logic [15:0]  hs;
        logic [31:0]  vs;
        logic [127:0] expd;
        logic [10:0]  ep;
        int hw, vw;
        hs = f_h(flip);
        vs = f_v(flip);
        expd = orig ^ flip ^ f_mask(hs, vs);
        hw = 0; vw = 0;
        for (int i = 0; i < 16; i++) hw += hs[i];
        for (int i = 0; i < 32; i++) vw += vs[i];
        ep = {hw[4:0], vw[5:0]};
        @(negedge clk);
        data_i = orig ^ flip;
        hpar_i = f_h(orig);
        vpar_i = f_v(orig);
        @(posedge clk);
        @(negedge clk);
        chk(data_o == expd, {tag, " R2 data"}, data_o, expd);
        chk(err_o == ((hs != 0) || (vs != 0)), "R3 flag", 128'(err_o), 128'((hs != 0) || (vs != 0)));
        chk(pred_o == ep, "R5 prediction", 128'(pred_o), 128'(ep));
        if (restore) chk(data_o == orig, {tag, " R9 restore"}, data_o, orig);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] base;
        // R1: reset holds outputs at zero even with a mismatching input.
        data_i = rnd128();
        hpar_i = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(data_o == '0 && err_o == 1'b0 && pred_o == '0, "R1 reset",
            data_o, 128'h0);
        rst_n = 1'b1;

        // R4: clean groups.
        for (int i = 0; i < 6; i++) run_case(rnd128(), '0, 1'b1, "R4 clean");
        run_case('1, '0, 1'b1, "R4 clean ones");

        // R6/R9: every single-bit upset.
        base = rnd128();
        for (int b = 0; b < 128; b++) run_case(base, 128'(1) << b, 1'b1, "R6 single");

        // R6/R9: horizontally adjacent pairs in each row.
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 31; c++)
                run_case(base, 128'(3) << (r*32 + c), 1'b1, "R6 hpair");

        // R8: vertically adjacent pairs cancel the column syndrome.
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 32; c++)
                run_case(base, (128'(1) << (r*32 + c)) | (128'(1) << ((r+1)*32 + c)),
                         c >= 28, "R8 vpair");

        // R7: whole row 0 inverted; row 2 inverted goes to row 0 instead.
        run_case(base, 128'hFFFF_FFFF, 1'b1, "R7 row0");
        run_case(base, 128'hFFFF_FFFF << 64, 1'b0, "R7 row2");

        // R8: top symbol inverted in every row.
        run_case(base, {4{32'hF000_0000}}, 1'b1, "R8 topsym");

        // R6/R5: random multi-bit patterns against the model.
        for (int i = 0; i < 60; i++) run_case(rnd128(), rnd128() & rnd128() & rnd128(), 1'b0, "R6 random");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule